// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Command Front-End

This block is the serial face of a small three-wire EEPROM. A host selects it with a chip-select line, clocks instruction frames in on a serial data input with its own serial clock, and gets read data or busy/ready status back on a serial output. The serial output has a separate enable, so it can be wired as a tri-state pin. The host's pins are oversampled by a faster system clock. A frame opens with a start bit and a two-bit opcode. Then comes an address, and for write-type commands a data field. The block decodes seven commands and holds a write-enable latch. It serves reads, including endless sequential bursts, from a register array that it holds. A width-select pin picks between 16-bit words and 8-bit bytes.

The block does no programming itself. A complete and permitted program command becomes a one-cycle request to a separate self-timed engine when chip select falls. That engine reports busy while it works, and it updates the array through a byte-enabled write port.

Top module: `mwe_serial_eeprom_fe`

## Requirements
- R1: With CS high, zeros sampled on rising SK before the first 1 are ignored. The frame begins at the first 1.
- R2: When org_wide=1, addresses are 6 bits and data is 16 bits. When org_wide=0, addresses are 7-bit byte addresses and data is 8 bits. Byte b lives in word b>>1, in the upper half when b[0]=1 and in the lower half otherwise.
- R3: A frame with opcode 10 is a read. After the rising SK that delivers the last address bit, DO is enabled and shows a dummy 0. Each later rising SK presents the next data bit, most significant bit first.
- R4: While CS stays high, the following words stream out with no dummy bit, at address+1, +2 and so on. After the last location (63 when wide, 127 when narrow) the address wraps to 0.
- R5: The write-enable latch is clear after reset. Opcode 00 with the top two address bits 11 sets it, and with 00 it clears it. While it is clear, WRITE (01), ERASE (11), erase-all (00, top bits 10) and write-all (00, top bits 01) produce no request.
- R6: A complete programming frame sent while writes are enabled gives a one-cycle prog_req after CS falls. prog_op is 0 for write, 1 for erase, 2 for erase-all and 3 for write-all. prog_addr carries the received address bits, with the upper bit 0 in wide mode. prog_data carries the received data right-aligned, or zero for commands that carry no data.
- R7: After a request, while CS is high and before the next start bit, DO is enabled and shows 0 while eng_busy=1 and 1 while eng_busy=0. A 1 clocked in on DI returns DO to high impedance.
- R8: do_oe is 0 at all other times: with CS low, and while a command is being received.
- R9: Taking CS low part-way through a frame discards it, and the next frame is received from its start bit.
- R10: Reads work the same whether the write-enable latch is set or clear.
- R11: The array resets to all ones. An engine write with eng_we=1 updates, for each set bit of eng_wbe, that half of word eng_waddr. Bit 0 selects the lower half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| org_wide | input | 1 | 1 selects 16-bit words, 0 selects 8-bit bytes |
| cs | input | 1 | Chip select, active high |
| sk | input | 1 | Serial clock from the host |
| di | input | 1 | Serial data in, sampled on rising SK |
| do_data | output | 1 | Serial data out value |
| do_oe | output | 1 | Output enable for the serial data pin |
| prog_req | output | 1 | One-cycle program request to the engine |
| prog_op | output | 2 | Program operation code (R6) |
| prog_addr | output | 7 | Received address bits |
| prog_data | output | 16 | Received data bits, right-aligned |
| eng_busy | input | 1 | Engine is carrying out a program operation |
| eng_we | input | 1 | Engine write strobe into the array |
| eng_waddr | input | 6 | Word address of the engine write |
| eng_wbe | input | 2 | Half-word enables of the engine write |
| eng_wdata | input | 16 | Engine write data |

## Verification
The busiest edge in a burst is the one where the last bit of the final location has just left. The next rising SK must both wrap the read pointer and present the most significant bit of location 0, with no dummy bit in between. Bursts are started just below the top of the array in both widths to provoke it. The scoreboard's per-bit queue judges it by expecting location 0's bits to follow directly. A second pairing is tested on one SK edge, where the start bit ends the status display and opens a frame: DO must be released on that same edge.

// File: rtl/mwe_pkg.sv
`timescale 1ns/1ps
package mwe_pkg;
   typedef enum logic [1:0] {
      PG_WRITE     = 2'd0,
      PG_ERASE     = 2'd1,
      PG_ERASE_ALL = 2'd2,
      PG_WRITE_ALL = 2'd3
   } pg_op_e;

   typedef enum logic [2:0] {
      FS_IDLE, FS_OPC, FS_ADDR, FS_DATA, FS_READ, FS_HOLD
   } fs_e;
endpackage

// File: rtl/mwe_pin_sync.sv
`timescale 1ns/1ps
module mwe_pin_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_i,
   input  logic sk_i,
   input  logic di_i,
   output logic cs_o,
   output logic di_o,
   output logic sk_rise_o,
   output logic cs_fall_o
);
   localparam int NPIN = 3;

   if (STAGES < 2) begin : g_bad_stages
      $error("mwe_pin_sync: STAGES must be at least 2");
   end

   logic [NPIN-1:0] raw, synced;
   logic            sk_d, cs_d;

   assign raw = {di_i, sk_i, cs_i};

   for (genvar p = 0; p < NPIN; p++) begin : g_pin
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= '0;
         else        chain <= {chain[STAGES-2:0], raw[p]};
      end
      assign synced[p] = chain[STAGES-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sk_d <= 1'b0;
         cs_d <= 1'b0;
      end else begin
         sk_d <= synced[1];
         cs_d <= synced[0];
      end
   end

   assign cs_o      = synced[0];
   assign di_o      = synced[2];
   assign sk_rise_o = synced[1] & ~sk_d;
   assign cs_fall_o = ~synced[0] & cs_d;

   AST_SK_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      sk_rise_o |=> !sk_rise_o); // R1
endmodule

// File: rtl/mwe_word_store.sv
`timescale 1ns/1ps
module mwe_word_store #(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [1:0]        wbe,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);
   localparam int DEPTH = 1 << ADDR_W;
   localparam int HALF  = DATA_W / 2;

   for (genvar l = 0; l < 2; l++) begin : g_lane
      logic [HALF-1:0] lmem [DEPTH];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) lmem[i] <= '1;
         end else if (we && wbe[l]) begin
            lmem[waddr] <= wdata[l*HALF +: HALF];
         end
      end
      assign rdata[l*HALF +: HALF] = lmem[raddr];
   end
endmodule

// File: rtl/mwe_ctrl.sv
`timescale 1ns/1ps
module mwe_ctrl
   import mwe_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wide,
   input  logic                cs_q,
   input  logic                di_q,
   input  logic                sk_rise,
   input  logic                cs_fall,
   input  logic                eng_busy,
   input  logic [DATA_W-1:0]   rd_word,
   output logic [ADDR_W-1:0]   rd_waddr,
   output logic                do_bit_o,
   output logic                do_oe_o,
   output logic                req_o,
   output pg_op_e              req_op_o,
   output logic [ADDR_W:0]     req_addr_o,
   output logic [DATA_W-1:0]   req_data_o
);
   localparam int BA_W = ADDR_W + 1;
   localparam int HALF = DATA_W / 2;
   localparam int MAXF = (BA_W > DATA_W) ? BA_W : DATA_W;
   localparam int CW   = $clog2(MAXF + 1);

   fs_e               st;
   logic [CW-1:0]     cnt, rd_cnt;
   logic [1:0]        opc;
   logic [BA_W-1:0]   sh_a, rd_a;
   logic [DATA_W-1:0] sh_d;
   logic              wen, armed, status_md, do_bit;
   pg_op_e            arm_op;

   logic [CW-1:0]     alen, dlen, bit_idx;
   logic [BA_W-1:0]   a_nxt, rd_nxt;
   logic [1:0]        sel2;
   logic [DATA_W-1:0] cur_word;

   assign alen    = wide ? CW'(ADDR_W) : CW'(BA_W);
   assign dlen    = wide ? CW'(DATA_W) : CW'(HALF);
   assign a_nxt   = {sh_a[BA_W-2:0], di_q};
   assign sel2    = wide ? a_nxt[ADDR_W-1 -: 2] : a_nxt[BA_W-1 -: 2];
   assign bit_idx = dlen - CW'(1) - rd_cnt;
   assign rd_waddr = wide ? rd_a[ADDR_W-1:0] : rd_a[BA_W-1:1];
   assign rd_nxt  = wide ? {1'b0, rd_a[ADDR_W-1:0] + 1'b1} : rd_a + 1'b1;

   always_comb begin
      if (wide) cur_word = rd_word;
      else      cur_word = {{HALF{1'b0}}, rd_a[0] ? rd_word[DATA_W-1:HALF] : rd_word[HALF-1:0]};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= FS_IDLE;  cnt <= '0;  rd_cnt <= '0;  opc <= '0;
         sh_a <= '0;  sh_d <= '0;  rd_a <= '0;
         wen <= 1'b0;  armed <= 1'b0;  status_md <= 1'b0;  do_bit <= 1'b0;
         arm_op <= PG_WRITE;
         req_o <= 1'b0;  req_op_o <= PG_WRITE;  req_addr_o <= '0;  req_data_o <= '0;
      end else begin
         req_o <= 1'b0;
         if (!cs_q) begin
            st    <= FS_IDLE;
            cnt   <= '0;
            armed <= 1'b0;
            if (cs_fall && armed) begin
               req_o      <= 1'b1;
               req_op_o   <= arm_op;
               req_addr_o <= sh_a;
               req_data_o <= sh_d;
               status_md  <= 1'b1;
            end
         end else if (sk_rise) begin
            unique case (st)
               FS_IDLE: if (di_q) begin
                  st <= FS_OPC;  cnt <= '0;  sh_a <= '0;  sh_d <= '0;
                  status_md <= 1'b0;
               end
               FS_OPC: begin
                  opc <= {opc[0], di_q};
                  if (cnt == CW'(1)) begin st <= FS_ADDR; cnt <= '0; end
                  else cnt <= cnt + 1'b1;
               end
               FS_ADDR: begin
                  sh_a <= a_nxt;
                  if (cnt == alen - CW'(1)) begin
                     cnt <= '0;
                     st  <= FS_HOLD;
                     unique case (opc)
                        2'b10: begin
                           st <= FS_READ;  rd_a <= a_nxt;  rd_cnt <= '0;  do_bit <= 1'b0;
                        end
                        2'b01: st <= FS_DATA;
                        2'b11: begin armed <= wen; arm_op <= PG_ERASE; end
                        default: unique case (sel2)
                           2'b11: wen <= 1'b1;
                           2'b00: wen <= 1'b0;
                           2'b10: begin armed <= wen; arm_op <= PG_ERASE_ALL; end
                           default: st <= FS_DATA;
                        endcase
                     endcase
                  end else cnt <= cnt + 1'b1;
               end
               FS_DATA: begin
                  sh_d <= {sh_d[DATA_W-2:0], di_q};
                  if (cnt == dlen - CW'(1)) begin
                     st     <= FS_HOLD;
                     armed  <= wen;
                     arm_op <= (opc == 2'b01) ? PG_WRITE : PG_WRITE_ALL;
                  end else cnt <= cnt + 1'b1;
               end
               FS_READ: begin
                  do_bit <= cur_word[bit_idx];
                  if (rd_cnt == dlen - CW'(1)) begin
                     rd_cnt <= '0;
                     rd_a   <= rd_nxt;
                  end else rd_cnt <= rd_cnt + 1'b1;
               end
               default: ;
            endcase
         end
      end
   end

   assign do_oe_o  = cs_q & ((st == FS_READ) | ((st == FS_IDLE) & status_md));
   assign do_bit_o = (st == FS_READ) ? do_bit : ~eng_busy;

   AST_REQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      req_o |-> wen); // R5
   AST_REQ_AT_CS_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      req_o |-> $past(cs_fall)); // R6
   AST_DO_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_q |-> !do_oe_o); // R8
   AST_DUMMY_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (st == FS_READ && $past(st) != FS_READ) |-> !do_bit_o); // R3
endmodule

// File: rtl/mwe_serial_eeprom_fe.sv
`timescale 1ns/1ps
module mwe_serial_eeprom_fe
   import mwe_pkg::*;
#(
   parameter int ADDR_W    = 6,
   parameter int DATA_W    = 16,
   parameter int SYNC_STG  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              org_wide,
   input  logic              cs,
   input  logic              sk,
   input  logic              di,
   output logic              do_data,
   output logic              do_oe,
   output logic              prog_req,
   output logic [1:0]        prog_op,
   output logic [ADDR_W:0]   prog_addr,
   output logic [DATA_W-1:0] prog_data,
   input  logic              eng_busy,
   input  logic              eng_we,
   input  logic [ADDR_W-1:0] eng_waddr,
   input  logic [1:0]        eng_wbe,
   input  logic [DATA_W-1:0] eng_wdata
);
   if (DATA_W < 2 || (DATA_W % 2) != 0) begin : g_bad_width
      $error("mwe_serial_eeprom_fe: DATA_W must be even and at least 2");
   end
   if (ADDR_W < 2) begin : g_bad_addr
      $error("mwe_serial_eeprom_fe: ADDR_W must be at least 2");
   end

   logic              cs_q, di_q, sk_rise, cs_fall;
   logic [ADDR_W-1:0] rd_waddr;
   logic [DATA_W-1:0] rd_word;
   pg_op_e            req_op;

   mwe_pin_sync #(.STAGES(SYNC_STG)) u_sync (
      .clk(clk), .rst_n(rst_n), .cs_i(cs), .sk_i(sk), .di_i(di),
      .cs_o(cs_q), .di_o(di_q), .sk_rise_o(sk_rise), .cs_fall_o(cs_fall)
   );

   mwe_word_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
      .clk(clk), .rst_n(rst_n), .we(eng_we), .waddr(eng_waddr), .wbe(eng_wbe),
      .wdata(eng_wdata), .raddr(rd_waddr), .rdata(rd_word)
   );

   mwe_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .wide(org_wide), .cs_q(cs_q), .di_q(di_q),
      .sk_rise(sk_rise), .cs_fall(cs_fall), .eng_busy(eng_busy), .rd_word(rd_word),
      .rd_waddr(rd_waddr), .do_bit_o(do_data), .do_oe_o(do_oe), .req_o(prog_req),
      .req_op_o(req_op), .req_addr_o(prog_addr), .req_data_o(prog_data)
   );

   assign prog_op = req_op;
endmodule

// File: tb/mwe_serial_eeprom_fe_tb.sv
`timescale 1ns/1ps
module mwe_serial_eeprom_fe_tb;
   localparam int AW = 6, DW = 16, DEPTH = 64;

   logic clk = 1'b0, rst_n = 1'b0, org_wide = 1'b1;
   logic cs = 1'b0, sk = 1'b0, di = 1'b0;
   logic eng_busy = 1'b0, eng_we = 1'b0;
   logic [AW-1:0] eng_waddr = '0;
   logic [1:0]    eng_wbe = '0;
   logic [DW-1:0] eng_wdata = '0;
   logic do_data, do_oe, prog_req;
   logic [1:0]    prog_op;
   logic [AW:0]   prog_addr;
   logic [DW-1:0] prog_data;

   int checks = 0, errors = 0;
   logic [DW-1:0] shadow [DEPTH];

   typedef struct { bit care; bit oe; bit val; string tag; } do_exp_t;
   typedef struct { logic [1:0] op; logic [AW:0] addr; logic [DW-1:0] data; bit wide; } req_exp_t;
   do_exp_t  doq[$];
   req_exp_t reqq[$];
   event smp_ev;

   always #2.5 clk = ~clk;

   mwe_serial_eeprom_fe u_dut (
      .clk(clk), .rst_n(rst_n), .org_wide(org_wide), .cs(cs), .sk(sk), .di(di),
      .do_data(do_data), .do_oe(do_oe), .prog_req(prog_req), .prog_op(prog_op),
      .prog_addr(prog_addr), .prog_data(prog_data), .eng_busy(eng_busy),
      .eng_we(eng_we), .eng_waddr(eng_waddr), .eng_wbe(eng_wbe), .eng_wdata(eng_wdata)
   );

   task automatic note(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic finish_run;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   // monitor: pops one expectation per sampled SK period
   initial forever begin
      @(smp_ev);
      if (doq.size() == 0) note(1'b0, "R8", "sample without expectation", 0, 0);
      else begin
         do_exp_t e;
         e = doq.pop_front();
         if (e.care) begin
            note(do_oe === e.oe, e.tag, "DO enable", {31'd0, do_oe}, {31'd0, e.oe});
            if (e.oe) note(do_data === e.val, e.tag, "DO bit", {31'd0, do_data}, {31'd0, e.val});
         end
      end
   end

   task automatic wr(input int a, input logic [1:0] be, input logic [DW-1:0] d);
      eng_waddr = AW'(a); eng_wbe = be; eng_wdata = d; eng_we = 1'b1;
      if (be[0]) shadow[a][7:0]  = d[7:0];
      if (be[1]) shadow[a][15:8] = d[15:8];
      @(negedge clk);
      eng_we = 1'b0;
   endtask

   // program engine model: checks each request against the driver's queue
   initial forever begin
      @(posedge clk);
      if (prog_req === 1'b1) begin
         req_exp_t e;
         if (reqq.size() == 0) begin
            note(1'b0, "R5", "request not expected", {30'd0, prog_op}, 0);
         end else begin
            e = reqq.pop_front();
            note(prog_op == e.op, "R6", "prog_op", {30'd0, prog_op}, {30'd0, e.op});
            note(prog_addr == e.addr, "R6", "prog_addr", {25'd0, prog_addr}, {25'd0, e.addr});
            note(prog_data == e.data, "R6", "prog_data", {16'd0, prog_data}, {16'd0, e.data});
            @(negedge clk);
            eng_busy = 1'b1;
            repeat (40) @(negedge clk);
            case (e.op)
               2'd0: if (e.wide) wr(int'(e.addr[5:0]), 2'b11, e.data);
                     else wr(int'(e.addr[6:1]), e.addr[0] ? 2'b10 : 2'b01, {e.data[7:0], e.data[7:0]});
               2'd1: if (e.wide) wr(int'(e.addr[5:0]), 2'b11, '1);
                     else wr(int'(e.addr[6:1]), e.addr[0] ? 2'b10 : 2'b01, '1);
               2'd2: for (int i = 0; i < DEPTH; i++) wr(i, 2'b11, '1);
               default: for (int i = 0; i < DEPTH; i++)
                  wr(i, 2'b11, e.wide ? e.data : {e.data[7:0], e.data[7:0]});
            endcase
            eng_busy = 1'b0;
         end
      end
   end

   task automatic pulse(input bit d, input bit care, input bit eoe, input bit ev, input string tag);
      do_exp_t e;
      e.care = care; e.oe = eoe; e.val = ev; e.tag = tag;
      @(negedge clk); di = d;
      repeat (3) @(negedge clk); sk = 1'b1;
      repeat (4) @(negedge clk);
      doq.push_back(e);
      ->smp_ev;
      sk = 1'b0;
   endtask

   task automatic cs_on;
      @(negedge clk); cs = 1'b1;
      repeat (2) @(negedge clk);
   endtask

   task automatic cs_off;
      @(negedge clk); cs = 1'b0; di = 1'b0;
      repeat (6) @(negedge clk);
   endtask

   function automatic logic [DW-1:0] exp_unit(input bit wide, input int a);
      if (wide) return shadow[a % DEPTH];
      return (a % 2 == 1) ? {8'h00, shadow[(a % (2*DEPTH)) / 2][15:8]}
                          : {8'h00, shadow[(a % (2*DEPTH)) / 2][7:0]};
   endfunction

   task automatic rd(input bit wide, input int a, input int nw, input int lead, input string tag);
      int n, dl, dep;
      logic [DW-1:0] u;
      n = wide ? AW : AW + 1; dl = wide ? DW : DW / 2; dep = wide ? DEPTH : 2 * DEPTH;
      org_wide = wide;
      cs_on;
      for (int i = 0; i < lead; i++) pulse(1'b0, 1'b1, 1'b0, 1'b0, "R1");
      pulse(1'b1, 1'b1, 1'b0, 1'b0, tag);
      pulse(1'b1, 1'b1, 1'b0, 1'b0, tag);
      pulse(1'b0, 1'b1, 1'b0, 1'b0, tag);
      for (int i = n - 1; i >= 1; i--) pulse(a[i], 1'b1, 1'b0, 1'b0, "R8");
      pulse(a[0], 1'b1, 1'b1, 1'b0, "R3");
      for (int w = 0; w < nw; w++) begin
         u = exp_unit(wide, (a + w) % dep);
         for (int b = dl - 1; b >= 0; b--) pulse(1'b0, 1'b1, 1'b1, u[b], (w == 0) ? tag : "R4");
      end
      cs_off;
      note(do_oe == 1'b0, "R8", "DO enable after CS low", {31'd0, do_oe}, 0);
   endtask

   task automatic cmd(input bit wide, input logic [1:0] opc, input int a, input logic [DW-1:0] d,
                      input bit hasd, input bit expreq, input logic [1:0] op, input bit probe);
      int n, dl;
      req_exp_t r;
      n = wide ? AW : AW + 1; dl = wide ? DW : DW / 2;
      org_wide = wide;
      cs_on;
      pulse(1'b1, 1'b1, 1'b0, 1'b0, "R8");
      pulse(opc[1], 1'b1, 1'b0, 1'b0, "R8");
      pulse(opc[0], 1'b1, 1'b0, 1'b0, "R8");
      for (int i = n - 1; i >= 0; i--) pulse(a[i], 1'b1, 1'b0, 1'b0, "R8");
      if (hasd) for (int i = dl - 1; i >= 0; i--) pulse(d[i], 1'b1, 1'b0, 1'b0, "R8");
      if (expreq) begin
         r.op = op; r.addr = (AW+1)'(a); r.wide = wide;
         r.data = hasd ? (wide ? d : {8'h00, d[7:0]}) : '0;
         reqq.push_back(r);
      end
      cs_off;
      if (expreq && probe) begin
         cs_on;
         repeat (4) @(negedge clk);
         note(do_oe == 1'b1 && do_data == 1'b0, "R7", "busy status",
              {30'd0, do_oe, do_data}, 32'h2);
         wait (eng_busy == 1'b0);
         repeat (4) @(negedge clk);
         note(do_oe == 1'b1 && do_data == 1'b1, "R7", "ready status",
              {30'd0, do_oe, do_data}, 32'h3);
         pulse(1'b1, 1'b1, 1'b0, 1'b0, "R7");
         cs_off;
      end
      wait (eng_busy == 1'b0);
      repeat (2) @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      note(1'b0, "R8", "watchdog expired", 0, 1);
      finish_run;
   end

   initial begin
      for (int i = 0; i < DEPTH; i++) shadow[i] = '1;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      note(do_oe == 1'b0, "R8", "DO enable after reset", {31'd0, do_oe}, 0);
      note(prog_req == 1'b0, "R5", "request after reset", {31'd0, prog_req}, 0);
      rd(1'b1, 0, 1, 0, "R11");
      for (int i = 0; i < DEPTH; i++) wr(i, 2'b11, DW'((i * 16'h1357) ^ 16'h0F0F));
      rd(1'b1, 5, 3, 0, "R3");
      rd(1'b1, 62, 3, 0, "R4");
      rd(1'b0, 126, 3, 0, "R2");
      rd(1'b0, 11, 1, 0, "R2");
      rd(1'b1, 7, 1, 3, "R1");
      // write while disabled: no request, data kept
      cmd(1'b1, 2'b01, 3, 16'h1234, 1'b1, 1'b0, 2'd0, 1'b0);
      rd(1'b1, 3, 1, 0, "R10");
      cmd(1'b1, 2'b00, 6'b110000, '0, 1'b0, 1'b0, 2'd0, 1'b0);
      rd(1'b1, 2, 1, 0, "R10");
      cmd(1'b1, 2'b01, 3, 16'h1234, 1'b1, 1'b1, 2'd0, 1'b1);
      rd(1'b1, 3, 1, 0, "R6");
      cmd(1'b0, 2'b01, 9, 16'h005A, 1'b1, 1'b1, 2'd0, 1'b0);
      rd(1'b0, 9, 1, 0, "R2");
      rd(1'b1, 4, 1, 0, "R11");
      cmd(1'b1, 2'b11, 3, '0, 1'b0, 1'b1, 2'd1, 1'b0);
      rd(1'b1, 3, 1, 0, "R6");
      // aborted frame
      org_wide = 1'b1;
      cs_on;
      pulse(1'b1, 1'b1, 1'b0, 1'b0, "R9");
      pulse(1'b1, 1'b1, 1'b0, 1'b0, "R9");
      pulse(1'b0, 1'b1, 1'b0, 1'b0, "R9");
      pulse(1'b1, 1'b1, 1'b0, 1'b0, "R9");
      cs_off;
      rd(1'b1, 6, 1, 0, "R9");
      cmd(1'b1, 2'b00, 6'b010000, 16'hC33C, 1'b1, 1'b1, 2'd3, 1'b0);
      rd(1'b1, 62, 3, 0, "R4");
      cmd(1'b1, 2'b00, 6'b000000, '0, 1'b0, 1'b0, 2'd0, 1'b0);
      cmd(1'b1, 2'b00, 6'b100000, '0, 1'b0, 1'b0, 2'd0, 1'b0);
      rd(1'b1, 12, 1, 0, "R5");
      cmd(1'b0, 2'b00, 7'b1100000, '0, 1'b0, 1'b0, 2'd0, 1'b0);
      cmd(1'b0, 2'b00, 7'b1000000, '0, 1'b0, 1'b1, 2'd2, 1'b0);
      rd(1'b0, 0, 2, 0, "R6");
      rd(1'b1, 20, 1, 0, "R6");
      note(reqq.size() == 0, "R6", "requests not seen", reqq.size(), 0);
      finish_run;
   end
endmodule